// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block services a circular ring of receive descriptors that live in a word-wide local memory. Each descriptor has four 32-bit words: a status word, a control word, the buffer address and the link to the next descriptor. When the consumer raises a scan request, the walker inspects the descriptor under its ready pointer. A descriptor still owned by the hardware ends the scan with no further action. A complete frame that passes the error rules is offered to the consumer as a length and a buffer address. Every other descriptor is recycled at once. After an offer is accepted, that descriptor is also handed back to the hardware. The pointer then follows the link word.

The frame output is a valid/ready stream. Once `frm_valid` rises, the length, address and error flag stay frozen until `frm_ready` is high at a clock edge. The walker stalls in that state for as long as the consumer holds off, so back-pressure costs nothing but time. Memory reads have one cycle of latency, and only one read or one write is issued in any cycle. The bench fills every control word with 0x01000600 and every buffer address is aligned to 16 bytes. The walker does not interpret either of these.

Top module: `rx_ring_walker`

## Requirements
- R1: After reset the ready pointer equals the ring base (0x100 by default). No frame is offered, no memory access is issued and `scan_done` is low until a scan request arrives.
- R2: When bit 31 of the status word is set, the descriptor belongs to the hardware. The scan ends with `scan_done` and `hw_owned` both high. Nothing is offered, nothing is written and the pointer does not move.
- R3: A descriptor that lacks either the first-segment flag (status bit 9) or the last-segment flag (status bit 8) is recycled without being offered.
- R4: An offered frame carries a length equal to status bits [29:16] minus 4. Its address is word 2 of the descriptor.
- R5: When the error flag (status bit 15) is clear, the frame is offered with `frm_err` low. When the flag is set, the frame is offered with `frm_err` high only if `promisc` is high and the length exceeds 6. Otherwise it is recycled.
- R6: Recycling re-reads the status word. If bit 31 is clear, exactly 0x80000000 is written to it. If bit 31 is already set, `reuse_fault` pulses and no write is made.
- R7: After an offer or a recycle, the pointer takes the value of word 3 (byte offset 12). The last descriptor links back to the first, so the walk wraps around the ring.
- R8: Each scan request handles at most one descriptor. It ends with a single-cycle `scan_done` pulse. Without a request, the memory port stays idle.
- R9: While `frm_valid` is high and `frm_ready` is low, `frm_valid`, `frm_len`, `frm_addr` and `frm_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| promisc | input | 1 | Accept long frames that have the error flag set |
| scan_req | input | 1 | Start one scan while idle |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |
| hw_owned | output | 1 | Valid with scan_done: the descriptor belonged to the hardware |
| reuse_fault | output | 1 | Pulse: status word already owned when recycling |
| mem_rd_en | output | 1 | Read strobe, data returned on the next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd_en |
| frm_valid | output | 1 | Frame offer valid |
| frm_ready | input | 1 | Consumer accepts the offer |
| frm_len | output | 14 | Frame length, excluding the CRC |
| frm_addr | output | AW | Frame buffer address |
| frm_err | output | 1 | The offered frame had the error flag set |

## Verification
The assertions assume a memory that answers every read exactly one cycle later and that never writes on its own between the walker's read and its write of a status word. They also assume that link words hold aligned descriptor addresses. The bench's memory model meets these rules by updating its array only on the walker's strobes. The only exception is the deliberate fault test: there the bench sets the ownership bit while the walker is stalled on an offer, which is before the recycle re-read. The consumer ready is driven away from the clock edge and only after the offer is seen, so the stall-and-hold behaviour is exercised with zero waits and with long waits.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int OWN_BIT = 31;
  localparam int ES_BIT  = 15;
  localparam int FS_BIT  = 9;
  localparam int LS_BIT  = 8;
  localparam int LEN_LSB = 16;
  localparam int LEN_MSB = 29;
  localparam int LEN_W   = LEN_MSB - LEN_LSB + 1;
  localparam logic [31:0] HANDBACK = 32'h8000_0000;

  localparam logic [1:0] WSEL_STATUS = 2'd0;
  localparam logic [1:0] WSEL_BUF    = 2'd2;
  localparam logic [1:0] WSEL_LINK   = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_EVAL, ST_BUF, ST_OFFER,
    ST_CHECK, ST_VERIFY, ST_LINK, ST_ADV, ST_FINISH
  } rxr_state_e;
endpackage

// File: rtl/rxr_classify.sv
module rxr_classify
  import rxr_pkg::*;
#(
  parameter int CRC_BYTES   = 4,
  parameter int MIN_ERR_LEN = 6
) (
  input  logic [31:0]      status,
  input  logic             promisc,
  output logic             owned,
  output logic             deliver,
  output logic [LEN_W-1:0] frame_len,
  output logic             err_sum
);
  localparam logic [LEN_W-1:0] CRC_L  = LEN_W'(CRC_BYTES);
  localparam logic [LEN_W-1:0] THRESH = LEN_W'(CRC_BYTES + MIN_ERR_LEN);

  logic [LEN_W-1:0] raw_len;
  logic             whole;

  always_comb begin
    raw_len   = status[LEN_MSB:LEN_LSB];
    frame_len = raw_len - CRC_L;
    whole     = status[FS_BIT] && status[LS_BIT];
    err_sum   = status[ES_BIT];
    owned     = status[OWN_BIT];
    // comparing the raw field avoids a wrap for fields below the CRC size
    deliver   = !owned && whole && (!err_sum || (promisc && (raw_len > THRESH)));
  end
endmodule

// File: rtl/rxr_ptr.sv
module rxr_ptr #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] RING_BASE = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] next_addr,
  input  logic [1:0]    word_sel,
  output logic [AW-1:0] word_addr
);
  logic [AW-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= RING_BASE;
    else if (load) cur <= next_addr;
  end

  assign word_addr = cur + AW'({word_sel, 2'b00});

  // R7: links are descriptor aligned, so a word offset never carries
  p_link_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (word_addr[3:0] == {word_sel, 2'b00}));
endmodule

// File: rtl/rx_ring_walker.sv
module rx_ring_walker
  import rxr_pkg::*;
#(
  parameter int            AW          = 32,
  parameter logic [AW-1:0] RING_BASE   = 'h100,
  parameter int            CRC_BYTES   = 4,
  parameter int            MIN_ERR_LEN = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             promisc,
  input  logic             scan_req,
  output logic             scan_done,
  output logic             hw_owned,
  output logic             reuse_fault,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             frm_valid,
  input  logic             frm_ready,
  output logic [LEN_W-1:0] frm_len,
  output logic [AW-1:0]    frm_addr,
  output logic             frm_err
);
  rxr_state_e       state, nxt;
  logic             cls_owned, cls_deliver, cls_err;
  logic [LEN_W-1:0] cls_len;
  logic             own_q, err_q;
  logic [LEN_W-1:0] len_q;
  logic [AW-1:0]    buf_q;
  logic [1:0]       wsel;

  rxr_classify #(.CRC_BYTES(CRC_BYTES), .MIN_ERR_LEN(MIN_ERR_LEN)) u_cls (
    .status(mem_rdata), .promisc(promisc), .owned(cls_owned),
    .deliver(cls_deliver), .frame_len(cls_len), .err_sum(cls_err)
  );

  rxr_ptr #(.AW(AW), .RING_BASE(RING_BASE)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(state == ST_ADV),
    .next_addr(mem_rdata[AW-1:0]), .word_sel(wsel), .word_addr(mem_addr)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (scan_req) nxt = ST_FETCH;
      ST_FETCH:  nxt = ST_EVAL;
      ST_EVAL:   nxt = cls_owned ? ST_FINISH : (cls_deliver ? ST_BUF : ST_CHECK);
      ST_BUF:    nxt = ST_OFFER;
      ST_OFFER:  if (frm_ready) nxt = ST_CHECK;
      ST_CHECK:  nxt = ST_VERIFY;
      ST_VERIFY: nxt = ST_LINK;
      ST_LINK:   nxt = ST_ADV;
      ST_ADV:    nxt = ST_FINISH;
      ST_FINISH: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_EVAL: wsel = WSEL_BUF;
      ST_LINK: wsel = WSEL_LINK;
      default: wsel = WSEL_STATUS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      own_q <= 1'b0;
      err_q <= 1'b0;
      len_q <= '0;
      buf_q <= '0;
    end else begin
      state <= nxt;
      if (state == ST_EVAL) begin
        own_q <= cls_owned;
        err_q <= cls_err;
        len_q <= cls_len;
      end
      if (state == ST_BUF) buf_q <= mem_rdata[AW-1:0];
    end
  end

  // the buffer word is read speculatively in EVAL; it is dropped when unused
  assign mem_rd_en   = (state == ST_FETCH) || (state == ST_EVAL) ||
                       (state == ST_CHECK) || (state == ST_LINK);
  assign mem_wr_en   = (state == ST_VERIFY) && !mem_rdata[OWN_BIT];
  assign reuse_fault = (state == ST_VERIFY) &&  mem_rdata[OWN_BIT];
  assign mem_wdata   = HANDBACK;
  assign scan_done   = (state == ST_FINISH);
  assign hw_owned    = scan_done && own_q;
  assign frm_valid   = (state == ST_OFFER);
  assign frm_len     = len_q;
  assign frm_addr    = buf_q;
  assign frm_err     = err_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_len) &&
                                   $stable(frm_addr) && $stable(frm_err)));

  p_err_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_err) |-> (frm_len > LEN_W'(MIN_ERR_LEN)));

  p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en) && ($past(mem_addr) == mem_addr)));

  p_owned_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EVAL && mem_rdata[OWN_BIT]) |=> (scan_done && hw_owned && !mem_wr_en));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  p_single_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
endmodule

// File: tb/rx_ring_walker_test.sv
module rx_ring_walker_test;
  localparam int NDESC = 4;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] BUFB = 32'h2000;
  localparam int NV = 9;
  localparam logic [31:0] V_W0 [NV] = '{32'h0040_0300, 32'h8040_0300, 32'h0040_0200,
                                        32'h0040_8300, 32'h0040_8300, 32'h000A_8300,
                                        32'h000B_8300, 32'h05EE_0300, 32'h0040_0100};
  localparam bit          V_PR [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 0};
  localparam bit          V_DL [NV] = '{1, 0, 0, 0, 1, 0, 1, 1, 0};
  localparam int          V_LN [NV] = '{60, 0, 0, 0, 60, 0, 7, 1514, 0};
  localparam bit          V_ER [NV] = '{0, 0, 0, 0, 1, 0, 1, 0, 0};

  logic clk = 0, rst_n = 0, promisc = 0, scan_req = 0, frm_ready = 0;
  logic scan_done, hw_owned, reuse_fault, mem_rd_en, mem_wr_en, frm_valid, frm_err;
  logic [31:0] mem_addr, mem_wdata, frm_addr;
  logic [31:0] mem_rdata = '0;
  logic [13:0] frm_len;
  logic [31:0] mem [0:1023];

  int checks = 0, errors = 0, cycles = 0;
  int idx = 0;
  bit got_valid, got_fault, got_done, got_own, fetch_seen, stable_bad, wr_seen, done_twice;
  logic [31:0] fetch_addr, f_addr;
  logic [13:0] f_len;
  logic f_err;

  always #5 clk = ~clk;

  rx_ring_walker uut (
    .clk(clk), .rst_n(rst_n), .promisc(promisc), .scan_req(scan_req),
    .scan_done(scan_done), .hw_owned(hw_owned), .reuse_fault(reuse_fault),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .frm_valid(frm_valid),
    .frm_ready(frm_ready), .frm_len(frm_len), .frm_addr(frm_addr), .frm_err(frm_err)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_wr_en) mem[mem_addr[11:2]] = mem_wdata;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] daddr(input int k);
    return BASE + 32'(16 * k);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_desc(input int k, input logic [31:0] w0);
    mem[daddr(k) >> 2]       = w0;
    mem[(daddr(k) >> 2) + 1] = 32'h0100_0600;
    mem[(daddr(k) >> 2) + 2] = BUFB + 32'(k * 'h600);
    mem[(daddr(k) >> 2) + 3] = daddr((k + 1) % NDESC);
  endtask

  task automatic run_req(input logic prom, input int hold, input bit poison);
    int waited = 0;
    got_valid = 0; got_fault = 0; got_done = 0; got_own = 0;
    fetch_seen = 0; stable_bad = 0; wr_seen = 0; done_twice = 0;
    @(negedge clk); promisc = prom; scan_req = 1;
    @(negedge clk); scan_req = 0;
    for (int c = 0; c < 60 && !got_done; c++) begin
      if (mem_rd_en && !fetch_seen) begin fetch_seen = 1; fetch_addr = mem_addr; end
      if (mem_wr_en) wr_seen = 1;
      if (reuse_fault) got_fault = 1;
      if (frm_valid) begin
        if (!got_valid) begin
          got_valid = 1; f_len = frm_len; f_addr = frm_addr; f_err = frm_err;
          if (poison) mem[daddr(idx) >> 2] = mem[daddr(idx) >> 2] | 32'h8000_0000;
        end else if (frm_len !== f_len || frm_addr !== f_addr || frm_err !== f_err)
          stable_bad = 1;
        if (waited >= hold) frm_ready = 1; else waited++;
      end else frm_ready = 0;
      if (scan_done) begin got_done = 1; got_own = hw_owned; end
      @(negedge clk);
    end
    frm_ready = 0;
    if (scan_done) done_twice = 1;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int k = 0; k < NDESC; k++) set_desc(k, 32'h8000_0000);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", {31'd0, frm_valid}, 32'd0);
    chk("R1 done", {31'd0, scan_done}, 32'd0);
    chk("R1 rd", {31'd0, mem_rd_en}, 32'd0);
    rst_n = 1;
    // R8: no request, no access
    wr_seen = 0; fetch_seen = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (mem_rd_en) fetch_seen = 1;
      if (mem_wr_en) wr_seen = 1;
    end
    chk("R8 idle access", {30'd0, fetch_seen, wr_seen}, 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic own_e;
      own_e = V_W0[v][31];
      set_desc(idx, V_W0[v]);
      run_req(V_PR[v], v % 3, 0);
      chk(v == 0 ? "R1 first fetch" : "R7 fetch addr", fetch_addr, daddr(idx));
      chk("R2 hw_owned", {31'd0, got_own}, {31'd0, own_e});
      chk("R3/R5 offered", {31'd0, got_valid}, {31'd0, V_DL[v]});
      chk("R8 done once", {30'd0, got_done, done_twice}, 32'd2);
      if (V_DL[v]) begin
        chk("R4 len", {18'd0, f_len}, 32'(V_LN[v]));
        chk("R4 addr", f_addr, BUFB + 32'(idx * 'h600));
        chk("R5 err", {31'd0, f_err}, {31'd0, V_ER[v]});
      end
      chk("R6 status after", mem[daddr(idx) >> 2], own_e ? V_W0[v] : 32'h8000_0000);
      chk("R9 stable", {31'd0, stable_bad}, 32'd0);
      if (!own_e) idx = (idx + 1) % NDESC;
    end

    // R9: long back-pressure
    set_desc(idx, 32'h0100_0300);
    run_req(0, 6, 0);
    chk("R9 held offer", {30'd0, got_valid, stable_bad}, 32'd2);
    chk("R9 len", {18'd0, f_len}, 32'd252);
    idx = (idx + 1) % NDESC;

    // R6: ownership taken while the offer waits
    set_desc(idx, 32'h0020_0300);
    run_req(0, 2, 1);
    chk("R6 fault pulse", {31'd0, got_fault}, 32'd1);
    chk("R6 no write", {31'd0, wr_seen}, 32'd0);
    chk("R6 status kept", mem[daddr(idx) >> 2], 32'h8020_0300);
    idx = (idx + 1) % NDESC;

    // R7: pointer still advanced after fault
    set_desc(idx, 32'h8000_0000);
    run_req(0, 0, 0);
    chk("R7 after fault", fetch_addr, daddr(idx));
    chk("R2 owned stop", {31'd0, got_own}, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule